// File: doc/BRIEF.md
# SPI serial nonvolatile byte memory model

This block is a synthesizable behavioural model of a byte-addressed nonvolatile memory that is reached over a four-wire SPI link. A fast system clock oversamples chip select, serial clock, serial data in, the hold line and the write-protect pin. It decodes an 8-bit instruction, then a 16-bit address sent most significant bit first, then data. Serial data out is returned as a data bit `so` plus a drive enable `soOe`. A pad drives `so` when `soOe` is high and floats the line otherwise.

Write data is gathered in a page buffer. Raising chip select on a byte boundary starts a self-timed write cycle. That cycle copies the buffered bytes into the array, skipping any address that the block-protect level marks read-only, and then clears the write-enable latch. The length of the cycle is the parameter `WR_CYCLES`. Its default of 500000 system clocks equals 5 ms at 100 MHz. `ADDR_USED` sets how many low address bits select a byte: 15 for a 32K x 8 array, 14 for 16K x 8. The default is a small 2K x 8 array so that the model stays light to elaborate. A hold input suspends a transfer mid-byte and resumes it without loss.

Top module: `spi_nvm`

## Requirements
- R1: SI is captured on rising SCK edges and SO changes after falling SCK edges, most significant bit first. SCK may idle low (mode 0) or high (mode 3) when chip select falls.
- R2: Opcodes are 0x06 set-latch, 0x04 clear-latch, 0x05 status read, 0x01 status write, 0x03 read and 0x02 write. Read and write take a 16-bit address, high byte first, of which only the low `ADDR_USED` bits select the byte.
- R3: `soOe` is low whenever chip select is high and outside the data phase of a read or status read.
- R4: The status byte is bit0 busy, bit1 write-enable latch, bits3:2 protect level and bit7 protect-enable, with bits 6:4 reading 0. It reads 0x00 after reset.
- R5: 0x06 sets the latch and 0x04 clears it. A write or status write issued while the latch is clear is ignored.
- R6: Write data past the end of a `PAGE_BYTES` page wraps to the start of the same page. The write starts only if chip select rises after at least one whole data byte, with no partial byte pending.
- R7: A write cycle keeps busy high for `WR_CYCLES` clocks and clears the write-enable latch when it ends. A status write also runs one.
- R8: While busy, every instruction except status read is ignored.
- R9: A sequential read increments the address through the whole array and wraps from the last byte to address 0.
- R10: Protect level 01 makes the top quarter of the array read-only, 10 the top half and 11 all of it. Data bytes aimed at read-only addresses are discarded.
- R11: A status write is ignored when protect-enable (bit7) is set and `wpN` is low.
- R12: Hold low while SCK is low freezes the transfer and forces `soOe` low. Releasing hold while SCK is low resumes the same transfer, and SCK edges seen during the hold have no effect.
- R13: Chip select high abandons any partial instruction. The next command starts fresh after chip select falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Active-low transfer suspend |
| wpN | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out bit |
| soOe | output | 1 | Drive enable for the serial data out pad |

## Verification
The hardest condition to reach is a hold that falls mid-byte in a read. It has to land while SCK is low, see SCK pulses that must be ignored, and then release so that the rest of the byte and the next byte arrive intact. The bench reaches it with a bit-level transfer routine that drops hold after the fourth data bit, pulses SCK twice, releases hold with SCK low and compares both bytes. A second hard case is a command issued during the busy window. The bench makes the write cycle long enough that a latch-clear, a status read and a full read all fit inside it, and then shows that the latch and the array were left alone.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SROUT,
    ST_SRIN,
    ST_SKIP
  } serState_t;

  // strobes from serial control to the datapath
  typedef struct packed {
    logic addrByte;   // shift a received address byte in
    logic rdNext;     // advance read address over the whole array
    logic wrByte;     // store a received data byte in the page buffer
    logic setWel;
    logic clrWel;
    logic srByte;     // hold a received status byte
    logic pageOpen;   // clear page buffer valid flags
    logic commitPage; // start write cycle for the page
    logic commitSr;   // apply status byte and start write cycle
    logic shiftOut;   // present the next output bit
    logic srcStatus;  // output source is the status byte
  } dpStrobe_t;

endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
  parameter int              WIDTH  = 5,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= INIT;
    end else begin
      stage[0] <= rawIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/spi_nvm_ctl.sv
module spi_nvm_ctl
  import spi_nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic       siS,
  input  logic       holdS,
  input  logic       busy,
  input  logic       wel,
  output dpStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic [2:0] bitIdx,
  output logic       soOe,
  output logic       held
);

  logic      sckQ, csQ;
  serState_t state, nextSt;
  logic [6:0] shReg;
  logic [2:0] bitCnt;
  logic      addrCnt, isRead, gotByte;

  logic sckRise, sckFall, csRise, active, byteDone;

  assign sckRise  = sckS & ~sckQ;
  assign sckFall  = ~sckS & sckQ;
  assign csRise   = csS & ~csQ;
  assign active   = ~csS & ~held;
  assign byteDone = active & sckRise & (bitCnt == 3'd7);
  assign rxByte   = {shReg, siS};
  assign bitIdx   = bitCnt;

  always_comb begin
    stb           = '0;
    nextSt        = state;
    stb.srcStatus = (state == ST_SROUT);
    stb.shiftOut  = active & sckFall;
    if (byteDone) begin
      case (state)
        ST_OPC: begin
          nextSt = ST_SKIP;
          if (!busy || rxByte == OP_RDSR) begin
            case (rxByte)
              OP_WREN:  stb.setWel = 1'b1;
              OP_WRDI:  stb.clrWel = 1'b1;
              OP_RDSR:  nextSt = ST_SROUT;
              OP_WRSR:  if (wel) nextSt = ST_SRIN;
              OP_READ:  nextSt = ST_ADDR;
              OP_WRITE: if (wel) begin
                nextSt       = ST_ADDR;
                stb.pageOpen = 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_ADDR: begin
          stb.addrByte = 1'b1;
          if (addrCnt) nextSt = isRead ? ST_RDATA : ST_WDATA;
        end
        ST_RDATA: stb.rdNext = 1'b1;
        ST_WDATA: stb.wrByte = 1'b1;
        ST_SRIN:  stb.srByte = 1'b1;
        default: ;
      endcase
    end
    if (csRise && gotByte && bitCnt == 3'd0) begin
      if (state == ST_WDATA) stb.commitPage = 1'b1;
      if (state == ST_SRIN)  stb.commitSr   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      csQ     <= 1'b1;
      state   <= ST_OPC;
      shReg   <= '0;
      bitCnt  <= '0;
      addrCnt <= 1'b0;
      isRead  <= 1'b0;
      gotByte <= 1'b0;
      held    <= 1'b0;
      soOe    <= 1'b0;
    end else begin
      sckQ <= sckS;
      csQ  <= csS;
      if (csS) begin
        state   <= ST_OPC;
        bitCnt  <= '0;
        addrCnt <= 1'b0;
        gotByte <= 1'b0;
        held    <= 1'b0;
        soOe    <= 1'b0;
      end else begin
        if (!held && !holdS && !sckS) held <= 1'b1;
        else if (held && holdS && !sckS) held <= 1'b0;
        if (active && sckRise) begin
          shReg  <= {shReg[5:0], siS};
          bitCnt <= bitCnt + 3'd1;
        end
        if (byteDone) begin
          state <= nextSt;
          if (state == ST_OPC)  isRead  <= (rxByte == OP_READ);
          if (state == ST_ADDR) addrCnt <= ~addrCnt;
          if (state == ST_WDATA || state == ST_SRIN) gotByte <= 1'b1;
        end
        soOe <= active && (state == ST_RDATA || state == ST_SROUT);
      end
    end
  end

endmodule

// File: rtl/spi_nvm_dp.sv
module spi_nvm_dp
  import spi_nvm_pkg::*;
#(
  parameter int ADDR_USED  = 11,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] rxByte,
  input  logic [2:0] bitIdx,
  input  logic       wpS,
  output logic       busy,
  output logic       wel,
  output logic [1:0] bpLvl,
  output logic       memWe,
  output logic       soBit
);

  localparam int DEPTH   = 1 << ADDR_USED;
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int IDX_W   = PAGE_AW + 1;
  localparam int CNT_W   = $clog2(WR_CYCLES + 1);

  logic [7:0]            mem     [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_USED-1:0]  addrReg;
  logic                  wpen, srWpen;
  logic [1:0]            srBp;
  logic [CNT_W-1:0]      busyCnt;
  logic [IDX_W-1:0]      copyIdx;
  logic [7:0]            status, srcByte;

  logic                  copyActive;
  logic [PAGE_AW-1:0]    copySlot;
  logic [ADDR_USED-1:0]  copyAddr;
  logic                  srBlocked, cycleEnd;

  function automatic logic isLocked(input logic [ADDR_USED-1:0] a, input logic [1:0] lvl);
    case (lvl)
      2'b01:   return &a[ADDR_USED-1 -: 2];
      2'b10:   return a[ADDR_USED-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign status     = {wpen, 3'b000, bpLvl, wel, busy};
  assign copyActive = busy & ~copyIdx[PAGE_AW];
  assign copySlot   = copyIdx[PAGE_AW-1:0];
  assign copyAddr   = {addrReg[ADDR_USED-1:PAGE_AW], copySlot};
  assign memWe      = copyActive && pageValid[copySlot] && !isLocked(copyAddr, bpLvl);
  assign srBlocked  = wpen & ~wpS;
  assign cycleEnd   = busy && (busyCnt == CNT_W'(WR_CYCLES - 1));
  assign srcByte    = stb.srcStatus ? status : mem[addrReg];

  always_ff @(posedge clk) begin
    if (memWe) mem[copyAddr] <= pageBuf[copySlot];
    if (stb.wrByte) pageBuf[addrReg[PAGE_AW-1:0]] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      pageValid <= '0;
      wel       <= 1'b0;
      wpen      <= 1'b0;
      bpLvl     <= 2'b00;
      srWpen    <= 1'b0;
      srBp      <= 2'b00;
      busy      <= 1'b0;
      busyCnt   <= '0;
      copyIdx   <= '0;
      soBit     <= 1'b0;
    end else begin
      if (stb.addrByte) addrReg <= ADDR_USED'({addrReg[7:0], rxByte});
      if (stb.rdNext)   addrReg <= addrReg + ADDR_USED'(1);
      if (stb.wrByte) begin
        addrReg[PAGE_AW-1:0]               <= addrReg[PAGE_AW-1:0] + PAGE_AW'(1);
        pageValid[addrReg[PAGE_AW-1:0]]    <= 1'b1;
      end
      if (stb.pageOpen) pageValid <= '0;
      if (stb.setWel)   wel <= 1'b1;
      if (stb.clrWel)   wel <= 1'b0;
      if (stb.srByte) begin
        srWpen <= rxByte[7];
        srBp   <= rxByte[3:2];
      end
      if (stb.shiftOut) soBit <= srcByte[~bitIdx];

      if (busy) begin
        busyCnt <= busyCnt + CNT_W'(1);
        if (copyActive) copyIdx <= copyIdx + IDX_W'(1);
        if (cycleEnd) begin
          busy      <= 1'b0;
          wel       <= 1'b0;
          pageValid <= '0;
        end
      end
      if (stb.commitPage || (stb.commitSr && !srBlocked)) begin
        busy    <= 1'b1;
        busyCnt <= '0;
        copyIdx <= '0;
      end
      if (stb.commitSr && !srBlocked) begin
        wpen  <= srWpen;
        bpLvl <= srBp;
      end
    end
  end

endmodule

// File: rtl/spi_nvm.sv
module spi_nvm
  import spi_nvm_pkg::*;
#(
  parameter int ADDR_USED   = 11,
  parameter int PAGE_BYTES  = 64,
  parameter int WR_CYCLES   = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  input  logic wpN,
  output logic so,
  output logic soOe
);

  localparam int         PIN_CNT  = 5;
  localparam logic [4:0] PIN_INIT = 5'b10011; // cs, sck, si, hold, wp

  logic [PIN_CNT-1:0] pinSync;
  logic       csS, sckS, siS, holdS, wpS;
  dpStrobe_t  stb;
  logic [7:0] rxByte;
  logic [2:0] bitIdx;
  logic       held, busy, wel, memWe, soBit;
  logic [1:0] bpLvl;

  spi_nvm_sync #(
    .WIDTH (PIN_CNT),
    .STAGES(SYNC_STAGES),
    .INIT  (PIN_INIT)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({csN, sck, si, holdN, wpN}),
    .syncOut(pinSync)
  );

  assign {csS, sckS, siS, holdS, wpS} = pinSync;

  spi_nvm_ctl u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .csS   (csS),
    .sckS  (sckS),
    .siS   (siS),
    .holdS (holdS),
    .busy  (busy),
    .wel   (wel),
    .stb   (stb),
    .rxByte(rxByte),
    .bitIdx(bitIdx),
    .soOe  (soOe),
    .held  (held)
  );

  spi_nvm_dp #(
    .ADDR_USED (ADDR_USED),
    .PAGE_BYTES(PAGE_BYTES),
    .WR_CYCLES (WR_CYCLES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rxByte(rxByte),
    .bitIdx(bitIdx),
    .wpS   (wpS),
    .busy  (busy),
    .wel   (wel),
    .bpLvl (bpLvl),
    .memWe (memWe),
    .soBit (soBit)
  );

  assign so = soBit;

endmodule

// File: rtl/spi_nvm_chk.sv
module spi_nvm_chk #(
  parameter int WR_CYCLES = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       csS,
  input logic       held,
  input logic       soOe,
  input logic       busy,
  input logic       wel,
  input logic       memWe,
  input logic [1:0] bpLvl
);

  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else       busyRun <= busy ? busyRun + 1 : 0;
  end

  // R3: no drive while deselected
  a_r3_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !soOe);

  // R12: no drive while suspended
  a_r12_quiet_when_held: assert property (@(posedge clk) disable iff (!rstN)
    (held && $past(held)) |-> !soOe);

  // R7: busy window length
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == WR_CYCLES));

  // R7: latch cleared at end of cycle
  a_r7_latch_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R8: latch cannot be set during busy
  a_r8_no_latch_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !$past(busy));

  // R10: full lock stops every array write
  a_r10_full_lock: assert property (@(posedge clk) disable iff (!rstN)
    (bpLvl == 2'b11) |-> !memWe);

endmodule

bind spi_nvm spi_nvm_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .csS  (csS),
  .held (held),
  .soOe (soOe),
  .busy (busy),
  .wel  (wel),
  .memWe(memWe),
  .bpLvl(bpLvl)
);

// File: tb/sim_spi_nvm.sv
module sim_spi_nvm;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WRC        = 1500;
  localparam int AU         = 11;

  localparam logic [7:0] C_WREN = 8'h06, C_WRDI = 8'h04, C_RDSR = 8'h05;
  localparam logic [7:0] C_WRSR = 8'h01, C_READ = 8'h03, C_WRIT = 8'h02;

  // {write address, read address, data}
  localparam logic [39:0] VEC [6] = '{
    {16'h0010, 16'h0010, 8'hA5},
    {16'h07C0, 16'h07C0, 8'h3C},
    {16'hF805, 16'h0005, 8'h5A},
    {16'h0400, 16'h0400, 8'hC3},
    {16'h07FF, 16'h07FF, 8'h81},
    {16'h0000, 16'h0000, 8'h7E}
  };

  logic clk = 1'b0;
  logic rstN, csN, sck, si, holdN, wpN, so, soOe;
  logic mode3 = 1'b0;
  logic oeAcc;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_nvm #(.ADDR_USED(AU), .PAGE_BYTES(64), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .holdN(holdN), .wpN(wpN), .so(so), .soOe(soOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csLow();
    sck = mode3;
    tick(4);
    csN = 1'b0;
    tick(HALF);
  endtask

  task automatic csHigh();
    tick(HALF);
    csN = 1'b1;
    tick(HALF);
  endtask

  task automatic bitStep(input logic b, output logic r);
    if (mode3) sck = 1'b0;
    si = b;
    tick(HALF);
    r = so;
    oeAcc = oeAcc | soOe;
    sck = 1'b1;
    tick(HALF);
    if (!mode3) sck = 1'b0;
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - n; i--) bitStep(tx[i], rx[i]);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    csLow(); xfer(op, r); csHigh();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    csLow(); xfer(C_RDSR, r); xfer(8'h00, st); csHigh();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    csLow(); xfer(C_WRSR, r); xfer(v, r); csHigh();
  endtask

  task automatic writeSeq(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n);
    logic [7:0] r;
    csLow();
    xfer(C_WRIT, r); xfer(a[15:8], r); xfer(a[7:0], r);
    xfer(d0, r);
    if (n > 1) xfer(d1, r);
    if (n > 2) xfer(d2, r);
    csHigh();
  endtask

  task automatic readSeq(input logic [15:0] a, output logic [7:0] r0, output logic [7:0] r1);
    logic [7:0] r;
    csLow();
    xfer(C_READ, r); xfer(a[15:8], r); xfer(a[7:0], r);
    oeAcc = 1'b0;
    xfer(8'h00, r0); xfer(8'h00, r1);
    csHigh();
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic protWrite(input logic [15:0] a, input logic [7:0] d);
    cmd(C_WREN);
    writeSeq(a, d, 8'h00, 8'h00, 1);
    waitIdle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, r0, r1, r;
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; si = 1'b0; holdN = 1'b1; wpN = 1'b1;
    oeAcc = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // reset state
    chk("R3 oe after reset", {15'd0, soOe}, 16'h0000);
    rdsr(st);
    chk("R4 status after reset", {8'd0, st}, 16'h0000);

    // latch control
    cmd(C_WREN); rdsr(st);
    chk("R5 latch set", {8'd0, st}, 16'h0002);
    cmd(C_WRDI); rdsr(st);
    chk("R5 latch cleared", {8'd0, st}, 16'h0000);

    // vector table: write, status during cycle, status after, read back
    foreach (VEC[i]) begin
      cmd(C_WREN);
      writeSeq(VEC[i][39:24], VEC[i][7:0], 8'h00, 8'h00, 1);
      rdsr(st);
      chk("R7 busy and latch during cycle", {8'd0, st}, 16'h0003);
      waitIdle();
      rdsr(st);
      chk("R7 latch cleared after cycle", {8'd0, st}, 16'h0000);
      readSeq(VEC[i][23:8], r0, r1);
      chk("R2 R1 read back", {8'd0, r0}, {8'd0, VEC[i][7:0]});
      chk("R3 oe during read data", {15'd0, oeAcc}, 16'h0001);
    end
    chk("R3 oe after deselect", {15'd0, soOe}, 16'h0000);

    // R9 wrap over the end of the array
    readSeq(16'h07FF, r0, r1);
    chk("R9 last byte", {8'd0, r0}, 16'h0081);
    chk("R9 wrapped to zero", {8'd0, r1}, 16'h007E);

    // R5 write without latch is ignored
    writeSeq(16'h0010, 8'h11, 8'h00, 8'h00, 1);
    rdsr(st);
    chk("R5 no cycle without latch", {8'd0, st}, 16'h0000);
    readSeq(16'h0010, r0, r1);
    chk("R5 data kept without latch", {8'd0, r0}, 16'h00A5);

    // R8 commands during busy
    cmd(C_WREN);
    writeSeq(16'h0020, 8'h44, 8'h00, 8'h00, 1);
    cmd(C_WRDI);
    rdsr(st);
    chk("R8 clear-latch ignored while busy", {8'd0, st}, 16'h0003);
    readSeq(16'h0010, r0, r1);
    chk("R8 read ignored while busy", {15'd0, oeAcc}, 16'h0000);
    waitIdle();
    rdsr(st);
    chk("R8 idle after cycle", {8'd0, st}, 16'h0000);
    readSeq(16'h0020, r0, r1);
    chk("R8 write completed", {8'd0, r0}, 16'h0044);

    // R6 page wrap
    cmd(C_WREN);
    writeSeq(16'h047E, 8'hB1, 8'hB2, 8'hB3, 3);
    waitIdle();
    readSeq(16'h047E, r0, r1);
    chk("R6 page byte 62", {8'd0, r0}, 16'h00B1);
    chk("R6 page byte 63", {8'd0, r1}, 16'h00B2);
    readSeq(16'h0440, r0, r1);
    chk("R6 wrapped to page start", {8'd0, r0}, 16'h00B3);

    // R6 R13 partial data byte aborts the write
    cmd(C_WREN);
    csLow();
    xfer(C_WRIT, r); xfer(8'h00, r); xfer(8'h10, r);
    xferBits(8'hFF, 4, r);
    csHigh();
    rdsr(st);
    chk("R6 partial byte starts no cycle", {8'd0, st}, 16'h0002);
    readSeq(16'h0010, r0, r1);
    chk("R6 data kept after partial byte", {8'd0, r0}, 16'h00A5);
    cmd(C_WRDI);
    csLow(); xferBits(8'h00, 4, r); csHigh();
    rdsr(st);
    chk("R13 fresh command after abandon", {8'd0, st}, 16'h0000);

    // R10 protection levels
    cmd(C_WREN); wrsr(8'h04); waitIdle();
    rdsr(st);
    chk("R10 quarter level set", {8'd0, st}, 16'h0004);
    protWrite(16'h07C0, 8'h99);
    readSeq(16'h07C0, r0, r1);
    chk("R10 top quarter discarded", {8'd0, r0}, 16'h003C);
    protWrite(16'h0400, 8'h66);
    readSeq(16'h0400, r0, r1);
    chk("R10 below quarter written", {8'd0, r0}, 16'h0066);
    cmd(C_WREN); wrsr(8'h08); waitIdle();
    protWrite(16'h0400, 8'h77);
    readSeq(16'h0400, r0, r1);
    chk("R10 top half discarded", {8'd0, r0}, 16'h0066);
    cmd(C_WREN); wrsr(8'h0C); waitIdle();
    protWrite(16'h0010, 8'h22);
    readSeq(16'h0010, r0, r1);
    chk("R10 whole array discarded", {8'd0, r0}, 16'h00A5);

    // R11 status write protection
    cmd(C_WREN); wrsr(8'h8C); waitIdle();
    rdsr(st);
    chk("R11 protect-enable set", {8'd0, st}, 16'h008C);
    wpN = 1'b0;
    cmd(C_WREN); wrsr(8'h00);
    rdsr(st);
    chk("R11 status write blocked", {8'd0, st}, 16'h008E);
    wpN = 1'b1;
    wrsr(8'h00); waitIdle();
    rdsr(st);
    chk("R11 status write with pin high", {8'd0, st}, 16'h0000);

    // R12 hold in the middle of a read byte
    csLow();
    xfer(C_READ, r); xfer(8'h04, r); xfer(8'h7E, r);
    r0 = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) begin
        holdN = 1'b0;
        tick(HALF);
        chk("R12 oe off during hold", {15'd0, soOe}, 16'h0000);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        holdN = 1'b1;
        tick(HALF);
      end
      bitStep(1'b0, r0[i]);
    end
    xfer(8'h00, r1);
    csHigh();
    chk("R12 byte across hold", {8'd0, r0}, 16'h00B1);
    chk("R12 next byte after hold", {8'd0, r1}, 16'h00B2);

    // R1 mode 3
    mode3 = 1'b1;
    readSeq(16'h047E, r0, r1);
    chk("R1 mode 3 first byte", {8'd0, r0}, 16'h00B1);
    chk("R1 mode 3 second byte", {8'd0, r1}, 16'h00B2);
    cmd(C_WREN); rdsr(st);
    chk("R1 mode 3 status", {8'd0, st}, 16'h0002);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule